// File: doc/BRIEF.md
# Secondary Interrupt Aggregator with Direct Routing

This block gathers a set of level-sensitive interrupt request lines, lets software choose which of them take part in a single combined request, and sends that combined request to one input of a primary interrupt controller. A second, independent mask can route a fixed window of the inputs (bits 21 through 30 by default) straight to matching inputs of the primary controller. This lets time-critical sources skip the shared combined line.

Software reaches the block over a plain 32-bit register port: a word address, a write strobe, write data and registered read data. Bit 0 of the raw level can also be raised by software as a soft interrupt. The inputs are asynchronous to the bus clock, so each line passes through a synchronizer before it is captured into the raw level register.

Top module: `aux_irq_hub`

## Requirements
- R1: While reset is held and right after it is released, `irq_combined` and every bit of `irq_direct` are 0, and the enable mask, direct-route mask and soft interrupt bit all read 0.
- R2: A change on `irq_in` shows in the raw level after the third rising clock edge (two synchronizer stages plus the raw register), not earlier. Word offset 1 reads the raw level, whose bit 0 is the synchronized input 0 ORed with the soft interrupt bit.
- R3: Writing word offset 2 ORs the write data into the enable mask. Writing word offset 3 clears every mask bit where the write data is 1. Reading word offset 2 returns the mask.
- R4: Reading word offset 0 returns the raw level ANDed with the enable mask.
- R5: `irq_combined` is 1 exactly when raw level AND enable mask is nonzero. It reflects a register write right after the clock edge that takes the write.
- R6: A write to word offset 4 sets the soft interrupt bit, and a write to word offset 5 clears it. Each of these writes acts only when the write data is nonzero. Reading word offset 4 returns raw level bit 0 in bit 0, with all other bits 0.
- R7: Writing word offset 8 ORs into the direct-route mask only the write-data bits 21 to 30 (AND 0x7FE00000). Writing word offset 9 clears the mask bits where the data is 1. Reading word offset 8 returns the direct-route mask.
- R8: For each bit i from 21 to 30, `irq_direct[i]` equals raw level bit i AND direct-route mask bit i. Every other bit of `irq_direct` is 0.
- R9: Reads of word offsets other than 0, 1, 2, 4 and 8 return 0. Writes to offsets 0, 1, 6, 7 and 10 to 15 change no state.
- R10: `bus_rdata` is registered. It shows the data for the address presented at one rising edge from just after that edge, and it holds until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bus and the interrupt logic |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Level-sensitive interrupt requests, asynchronous |
| bus_addr | input | 4 | Word offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_combined | output | 1 | Combined request to the primary controller |
| irq_direct | output | 32 | Direct-routed requests, only bits 21 to 30 active |

## Verification
A mask write and a new input level can reach the registers on the same clock edge. When they do, the combined and direct outputs must show both changes at once. The bench times an input change so that it reaches the raw register on the edge that also takes an enable-set write, and later an enable-clear write. It then checks `irq_combined` and the status read against the result that combines both updates.

// File: rtl/aux_irq_pkg.sv
package aux_irq_pkg;

   localparam int DATA_W = 32;

   // Word offsets of the register port
   localparam int OFF_STATUS   = 0;
   localparam int OFF_RAW      = 1;
   localparam int OFF_EN_SET   = 2;
   localparam int OFF_EN_CLR   = 3;
   localparam int OFF_SOFT_SET = 4;
   localparam int OFF_SOFT_CLR = 5;
   localparam int OFF_PT_SET   = 8;
   localparam int OFF_PT_CLR   = 9;

   // Contiguous bit span [lo:hi] set to one
   function automatic logic [DATA_W-1:0] span_mask(input int lo, input int hi);
      logic [DATA_W-1:0] m;
      m = '0;
      for (int b = 0; b < DATA_W; b++) begin
         if (b >= lo && b <= hi) m[b] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/aux_irq_sync.sv
module aux_irq_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/aux_irq_regs.sv
module aux_irq_regs
   import aux_irq_pkg::*;
#(
   parameter int                  NUM_IRQ = 32,
   parameter int                  ADDR_W  = 4,
   parameter logic [NUM_IRQ-1:0]  PT_MASK = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] sync_lvl,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic [NUM_IRQ-1:0] raw_lvl,
   output logic [NUM_IRQ-1:0] en_mask,
   output logic [NUM_IRQ-1:0] pt_en
);

   logic [NUM_IRQ-1:0] raw_q;
   logic               soft_q;
   logic [NUM_IRQ-1:0] wd;
   logic               wd_nz;
   logic [DATA_W-1:0]  rd_next;

   assign wd      = bus_wdata[NUM_IRQ-1:0];
   assign wd_nz   = |bus_wdata;
   assign raw_lvl = raw_q | NUM_IRQ'(soft_q);

   always_ff @(posedge clk) begin
      if (!rst_n) raw_q <= '0;
      else        raw_q <= sync_lvl;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_mask <= '0;
         pt_en   <= '0;
         soft_q  <= 1'b0;
      end else if (bus_wr) begin
         case (bus_addr)
            ADDR_W'(OFF_EN_SET):   en_mask <= en_mask | wd;
            ADDR_W'(OFF_EN_CLR):   en_mask <= en_mask & ~wd;
            ADDR_W'(OFF_SOFT_SET): if (wd_nz) soft_q <= 1'b1;
            ADDR_W'(OFF_SOFT_CLR): if (wd_nz) soft_q <= 1'b0;
            ADDR_W'(OFF_PT_SET):   pt_en   <= pt_en | (wd & PT_MASK);
            ADDR_W'(OFF_PT_CLR):   pt_en   <= pt_en & ~wd;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (bus_addr)
         ADDR_W'(OFF_STATUS):   rd_next = DATA_W'(raw_lvl & en_mask);
         ADDR_W'(OFF_RAW):      rd_next = DATA_W'(raw_lvl);
         ADDR_W'(OFF_EN_SET):   rd_next = DATA_W'(en_mask);
         ADDR_W'(OFF_SOFT_SET): rd_next = DATA_W'(raw_lvl[0]);
         ADDR_W'(OFF_PT_SET):   rd_next = DATA_W'(pt_en);
         default:               rd_next = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) bus_rdata <= '0;
      else        bus_rdata <= rd_next;
   end

endmodule

// File: rtl/aux_irq_route.sv
module aux_irq_route #(
   parameter int NUM_IRQ = 32,
   parameter int PT_LO   = 21,
   parameter int PT_HI   = 30
) (
   input  logic [NUM_IRQ-1:0] raw_lvl,
   input  logic [NUM_IRQ-1:0] en_mask,
   input  logic [NUM_IRQ-1:0] pt_en,
   output logic               irq_combined,
   output logic [NUM_IRQ-1:0] irq_direct
);

   assign irq_combined = |(raw_lvl & en_mask);

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
      if (i >= PT_LO && i <= PT_HI) begin : g_route
         assign irq_direct[i] = raw_lvl[i] & pt_en[i];
      end else begin : g_tie
         assign irq_direct[i] = 1'b0;
      end
   end

endmodule

// File: rtl/aux_irq_hub.sv
module aux_irq_hub
   import aux_irq_pkg::*;
#(
   parameter int NUM_IRQ     = 32,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int PT_LO       = 21,
   parameter int PT_HI       = 30
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] irq_in,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               irq_combined,
   output logic [NUM_IRQ-1:0] irq_direct
);

   localparam logic [NUM_IRQ-1:0] PT_MASK = NUM_IRQ'(span_mask(PT_LO, PT_HI));

   if (NUM_IRQ < 1 || NUM_IRQ > DATA_W) begin : g_bad_width
      $error("NUM_IRQ must lie in 1..DATA_W");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W must cover word offset 9");
   end
   if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must lie in 2..4");
   end
   if (PT_LO < 1 || PT_LO > PT_HI || PT_HI >= NUM_IRQ) begin : g_bad_span
      $error("direct-route span must lie above bit 0 and inside NUM_IRQ");
   end

   logic [NUM_IRQ-1:0] sync_lvl;
   logic [NUM_IRQ-1:0] raw_lvl;
   logic [NUM_IRQ-1:0] en_mask;
   logic [NUM_IRQ-1:0] pt_en;

   aux_irq_sync #(
      .W      (NUM_IRQ),
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (irq_in),
      .q     (sync_lvl)
   );

   aux_irq_regs #(
      .NUM_IRQ (NUM_IRQ),
      .ADDR_W  (ADDR_W),
      .PT_MASK (PT_MASK)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_lvl  (sync_lvl),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .raw_lvl   (raw_lvl),
      .en_mask   (en_mask),
      .pt_en     (pt_en)
   );

   aux_irq_route #(
      .NUM_IRQ (NUM_IRQ),
      .PT_LO   (PT_LO),
      .PT_HI   (PT_HI)
   ) i_route (
      .raw_lvl      (raw_lvl),
      .en_mask      (en_mask),
      .pt_en        (pt_en),
      .irq_combined (irq_combined),
      .irq_direct   (irq_direct)
   );

endmodule

// File: rtl/aux_irq_hub_chk.sv
module aux_irq_hub_chk
   import aux_irq_pkg::*;
#(
   parameter int NUM_IRQ     = 32,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int PT_LO       = 21,
   parameter int PT_HI       = 30
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_IRQ-1:0] irq_in,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic               bus_wr,
   input logic [DATA_W-1:0]  bus_wdata,
   input logic [DATA_W-1:0]  bus_rdata,
   input logic               irq_combined,
   input logic [NUM_IRQ-1:0] irq_direct
);

   localparam logic [NUM_IRQ-1:0] PT_MASK  = NUM_IRQ'(span_mask(PT_LO, PT_HI));
   localparam logic [DATA_W-1:0]  PT_MASKW = span_mask(PT_LO, PT_HI);

   logic addr_undef;
   assign addr_undef = !(bus_addr == ADDR_W'(OFF_STATUS)   ||
                         bus_addr == ADDR_W'(OFF_RAW)      ||
                         bus_addr == ADDR_W'(OFF_EN_SET)   ||
                         bus_addr == ADDR_W'(OFF_SOFT_SET) ||
                         bus_addr == ADDR_W'(OFF_PT_SET));

   // R8
   direct_outside_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_direct & ~PT_MASK) == '0);

   // R2
   direct_needs_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_direct & ~$past(irq_in, SYNC_STAGES + 1)) == '0);

   // R5
   status_matches_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(OFF_STATUS)) |=> ((bus_rdata != '0) == $past(irq_combined)));

   // R9
   undef_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_undef |=> (bus_rdata == '0));

   // R7
   pt_read_in_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(OFF_PT_SET)) |=> ((bus_rdata & ~PT_MASKW) == '0));

   // R6
   soft_set_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFF_SOFT_SET) && bus_wdata != '0)
      ##1 (bus_addr == ADDR_W'(OFF_SOFT_SET)) |=> bus_rdata[0]);

endmodule

bind aux_irq_hub aux_irq_hub_chk #(
   .NUM_IRQ     (NUM_IRQ),
   .ADDR_W      (ADDR_W),
   .SYNC_STAGES (SYNC_STAGES),
   .PT_LO       (PT_LO),
   .PT_HI       (PT_HI)
) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .irq_in       (irq_in),
   .bus_addr     (bus_addr),
   .bus_wr       (bus_wr),
   .bus_wdata    (bus_wdata),
   .bus_rdata    (bus_rdata),
   .irq_combined (irq_combined),
   .irq_direct   (irq_direct)
);

// File: tb/test_aux_irq_hub.sv
module test_aux_irq_hub;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_in = '0;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_combined;
   logic [31:0] irq_direct;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   aux_irq_hub i_aux_irq_hub (
      .clk          (clk),
      .rst_n        (rst_n),
      .irq_in       (irq_in),
      .bus_addr     (bus_addr),
      .bus_wr       (bus_wr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .irq_combined (irq_combined),
      .irq_direct   (irq_direct)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input int off, input logic [31:0] d);
      bus_addr  = 4'(off);
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
      bus_wdata = '0;
   endtask

   task automatic rd_reg(input int off, output logic [31:0] d);
      bus_addr = 4'(off);
      bus_wr   = 1'b0;
      @(negedge clk);
      d = bus_rdata;
   endtask

   task automatic settle(input logic [31:0] lvl);
      irq_in = lvl;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      irq_in = 32'hFFFF_FFFF;
      repeat (4) @(negedge clk);
      chk("R1 comb in reset", 32'(irq_combined), 0);
      chk("R1 direct in reset", irq_direct, 0);
      rst_n = 1'b1;
      irq_in = '0;
      repeat (4) @(negedge clk);
      rd_reg(2, d); chk("R1 enable mask", d, 0);
      rd_reg(8, d); chk("R1 route mask", d, 0);
      rd_reg(4, d); chk("R1 soft bit", d, 0);
      chk("R1 comb after reset", 32'(irq_combined), 0);
   endtask

   task automatic t_enable();
      logic [31:0] d;
      wr_reg(2, 32'h0000_00F0);
      wr_reg(2, 32'h0000_0F00);
      wr_reg(3, 32'h0000_0030);
      rd_reg(2, d); chk("R3 set/clear mask", d, 32'h0000_0FC0);
      bus_addr = 4'd1;
      #1;
      chk("R10 rdata held before edge", bus_rdata, 32'h0000_0FC0);
      @(negedge clk);
      chk("R10 rdata after edge", bus_rdata, 0);
   endtask

   task automatic t_status();
      logic [31:0] d;
      irq_in = 32'h0000_0400;
      repeat (2) @(negedge clk);
      chk("R2 not yet visible", 32'(irq_combined), 0);
      @(negedge clk);
      chk("R5 comb on enabled input", 32'(irq_combined), 1);
      rd_reg(1, d); chk("R2 raw level", d, 32'h0000_0400);
      settle(32'h0000_0402);
      rd_reg(1, d); chk("R2 raw two bits", d, 32'h0000_0402);
      rd_reg(0, d); chk("R4 status masked", d, 32'h0000_0400);
      wr_reg(3, 32'h0000_0400);
      chk("R5 comb drops after clear", 32'(irq_combined), 0);
      rd_reg(0, d); chk("R4 status after clear", d, 0);
      settle('0);
   endtask

   task automatic t_soft();
      logic [31:0] d;
      wr_reg(4, 32'h0);
      rd_reg(4, d); chk("R6 zero-data set ignored", d, 0);
      wr_reg(4, 32'h0000_0005);
      rd_reg(4, d); chk("R6 soft set", d, 1);
      rd_reg(1, d); chk("R6 soft in raw bit 0", d, 1);
      chk("R5 soft masked off", 32'(irq_combined), 0);
      wr_reg(2, 32'h1);
      chk("R5 soft enabled", 32'(irq_combined), 1);
      wr_reg(5, 32'h0);
      rd_reg(4, d); chk("R6 zero-data clear ignored", d, 1);
      wr_reg(5, 32'h8000_0000);
      rd_reg(4, d); chk("R6 soft clear", d, 0);
      chk("R5 comb after soft clear", 32'(irq_combined), 0);
      wr_reg(3, 32'h1);
   endtask

   task automatic t_route();
      logic [31:0] d;
      wr_reg(8, 32'hFFFF_FFFF);
      rd_reg(8, d); chk("R7 set limited to span", d, 32'h7FE0_0000);
      settle(32'hFFFF_FFFF);
      chk("R8 direct all span", irq_direct, 32'h7FE0_0000);
      wr_reg(9, 32'h0FE0_0000);
      chk("R8 direct after clear", irq_direct, 32'h7000_0000);
      rd_reg(8, d); chk("R7 clear", d, 32'h7000_0000);
      settle(32'hDFFF_FFFF);
      chk("R8 direct follows level", irq_direct, 32'h5000_0000);
      wr_reg(9, 32'hFFFF_FFFF);
      wr_reg(3, 32'hFFFF_FFFF);
      settle('0);
      chk("R8 direct all low", irq_direct, 0);
   endtask

   task automatic t_undef();
      logic [31:0] d;
      wr_reg(2, 32'h0000_0010);
      foreach (d[k]) ;
      for (int off = 0; off < 16; off++) begin
         if (off == 3 || off == 5 || off == 6 || off == 7 || off >= 9) begin
            rd_reg(off, d);
            chk($sformatf("R9 undefined read %0d", off), d, 0);
         end
      end
      wr_reg(0, 32'hFFFF_FFFF);
      wr_reg(1, 32'hFFFF_FFFF);
      wr_reg(6, 32'hFFFF_FFFF);
      wr_reg(7, 32'hFFFF_FFFF);
      wr_reg(12, 32'hFFFF_FFFF);
      rd_reg(2, d); chk("R9 mask unchanged", d, 32'h0000_0010);
      rd_reg(8, d); chk("R9 route unchanged", d, 0);
      rd_reg(4, d); chk("R9 soft unchanged", d, 0);
      rd_reg(1, d); chk("R9 raw unchanged", d, 0);
      wr_reg(3, 32'hFFFF_FFFF);
   endtask

   task automatic t_same_cycle();
      logic [31:0] d;
      irq_in = 32'h0040_0000;
      repeat (2) @(negedge clk);
      wr_reg(2, 32'h0040_0000);
      chk("R5 input and enable same edge", 32'(irq_combined), 1);
      rd_reg(0, d); chk("R4 status same edge", d, 32'h0040_0000);
      irq_in = '0;
      repeat (2) @(negedge clk);
      wr_reg(3, 32'h0040_0000);
      chk("R5 drop and clear same edge", 32'(irq_combined), 0);
      rd_reg(2, d); chk("R3 mask after same-edge clear", d, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         bad++;
         total++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_enable();
      t_status();
      t_soft();
      t_route();
      t_undef();
      t_same_cycle();
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule